// File: doc/BRIEF.md
# Event Priority Vectoring Unit

This unit sits at the instruction-boundary point of a processor core and decides which pending event is taken next. Six request lines feed it: an exception raised by the instruction that just retired, a non-maskable external interrupt, a maskable external interrupt, and faults reported by the fetch, decode and execute stages. Each line comes with its own 8-bit vector number. On every cycle where the boundary strobe is high, the unit picks the highest-ranked eligible request. One cycle later it presents that request's vector number and the byte address of its handler entry.

The handler table has 256 slots, each a 32-bit handler address, so the entry address is the table base plus four times the vector number. The unit also returns a one-hot acknowledge naming the chosen source. The requester drops its pending flag on that acknowledge, and every other request stays pending for a later boundary. The table contents, handler execution and state saving belong to neighbouring logic.

Top module: `evt_vector_sel`

## Requirements
- R1: After reset, `take_o` is 0, `ack_o` is 0, and `vec_o` and `entry_o` are 0.
- R2: A decision is made only on a rising clock edge where `boundary_i` is 1. With `boundary_i` at 0, `take_o` and `ack_o` are 0 in the following cycle, whatever is pending.
- R3: Request bits in `pend_i` rank by index, with bit 0 highest: bit 0 is the previous-instruction exception, bit 1 the non-maskable interrupt, bit 2 the maskable interrupt, bit 3 the fetch fault, bit 4 the decode fault and bit 5 the execute fault. The lowest-indexed eligible bit is selected.
- R4: While `irq_en_i` is 0, bit 2 is not eligible and is never selected, and the selection falls to the next eligible bit.
- R5: Bit 1 is selected regardless of `irq_en_i`, and it wins over bit 2 when both are pending.
- R6: `entry_o` equals `tbl_base_i + 4*vec_o`, modulo 2^32, using the base present at the decision edge.
- R7: `take_o` is 1 for exactly one cycle per decision. The cycle after a decision is low when `boundary_i` was low at the next edge.
- R8: `ack_o` is one-hot on the selected bit position in the cycle where `take_o` is 1, and is zero otherwise.
- R9: When no bit is eligible at a boundary, `take_o` and `ack_o` stay 0 and `vec_o`/`entry_o` keep their previous values.
- R10: `vec_o` is the field `vecs_i[8*k+7:8*k]` of the selected bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe; a decision is made on edges where it is high |
| irq_en_i | input | 1 | Maskable-interrupt enable |
| pend_i | input | 6 | Pending requests, bit 0 highest rank |
| vecs_i | input | 48 | Per-source vector numbers, 8 bits each, source k at bits 8k+7:8k |
| tbl_base_i | input | 32 | Byte address of handler table slot 0 |
| take_o | output | 1 | One-cycle pulse: a request was selected |
| ack_o | output | 6 | One-hot acknowledge of the selected source |
| vec_o | output | 8 | Selected vector number |
| entry_o | output | 32 | Byte address of the selected handler entry |

## Verification
The bench sweeps all 64 pending patterns with the enable both set and clear, and sets a distinct vector number in every field. A priority encoder that was reversed, or off by one position, would acknowledge the wrong bit and return the wrong field. A mask applied to the wrong bit, or applied to the non-maskable line, would surface when only bits 1 and 2 are pending with the enable clear. Table bases near the top of the address space make the entry addition wrap, which exposes a shift by the wrong amount or a truncated adder. Held requests with the strobe low, and a drain that clears one acknowledged source at a time, catch a unit that decides without the strobe or that stretches its pulse.

// File: rtl/evt_vector_sel.sv
module evt_vector_sel #(
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary_i,
  input  logic                irq_en_i,
  input  logic [5:0]          pend_i,
  input  logic [6*VEC_W-1:0]  vecs_i,
  input  logic [ADDR_W-1:0]   tbl_base_i,
  output logic                take_o,
  output logic [5:0]          ack_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic [ADDR_W-1:0]   entry_o
);
  localparam int NSRC  = 6;
  localparam int SEL_W = $clog2(NSRC);

  logic [NSRC-1:0]  elig;
  logic [SEL_W-1:0] sel;
  logic [VEC_W-1:0] pick;
  logic             fire;

  // bit 2 is the only maskable source
  assign elig = pend_i & {3'b111, irq_en_i, 2'b11};
  assign fire = boundary_i & (|elig);

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) sel = SEL_W'(i);
  end

  assign pick = vecs_i[sel*VEC_W +: VEC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o  <= 1'b0;
      ack_o   <= '0;
      vec_o   <= '0;
      entry_o <= '0;
    end else begin
      take_o <= fire;
      ack_o  <= fire ? (NSRC'(1) << sel) : '0;
      if (fire) begin
        vec_o   <= pick;
        entry_o <= tbl_base_i + (ADDR_W'(pick) << ENTRY_LOG2);
      end
    end
  end

  assert_ack_matches_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o) && ((|ack_o) == take_o));

  assert_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  assert_mask_honoured_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && ack_o[2]) |-> $past(irq_en_i));

  assert_acked_was_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(pend_i) & ack_o) != '0));

  assert_highest_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(pend_i & {3'b111, irq_en_i, 2'b11}) & (ack_o - 6'd1)) == '0));

  assert_holds_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> (take_o || ($stable(vec_o) && $stable(entry_o))));
endmodule

// File: tb/tb_evt_vector_sel.sv
module tb_evt_vector_sel;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic [5:0]  pend_i = '0;
  logic [47:0] vecs_i = '0;
  logic [31:0] tbl_base_i = '0;
  logic        take_o;
  logic [5:0]  ack_o;
  logic [7:0]  vec_o;
  logic [31:0] entry_o;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  evt_vector_sel dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [5:0] p, input logic en);
    logic [5:0] e = p & {3'b111, en, 2'b11};
    for (int i = 0; i < 6; i++) if (e[i]) return i;
    return -1;
  endfunction

  task automatic decide(input logic [5:0] p, input logic en, input logic [47:0] v, input logic [31:0] b,
                        output int k);
    logic [7:0]  ev;
    logic [31:0] ea;
    logic [7:0]  prev_v;
    logic [31:0] prev_a;
    prev_v = vec_o; prev_a = entry_o;
    @(negedge clk);
    pend_i = p; irq_en_i = en; vecs_i = v; tbl_base_i = b; boundary_i = 1'b1;
    k = model_pick(p, en);
    @(posedge clk); #1;
    if (k < 0) begin
      chk(take_o == 1'b0, "R9 take", 32'(take_o), 0);
      chk(ack_o == '0, "R9 ack", 32'(ack_o), 0);
      chk(vec_o == prev_v && entry_o == prev_a, "R9 hold", entry_o, prev_a);
    end else begin
      ev = v[8*k +: 8];
      ea = b + {22'd0, ev, 2'b00};
      chk(take_o == 1'b1, "R3 take", 32'(take_o), 1);
      chk(ack_o == (6'd1 << k), (en ? "R3/R5 ack" : "R4 ack"), 32'(ack_o), 32'(6'd1 << k));
      chk(vec_o == ev, "R10 vec", 32'(vec_o), 32'(ev));
      chk(entry_o == ea, "R6 entry", entry_o, ea);
    end
    @(negedge clk);
    boundary_i = 1'b0;
    @(posedge clk); #1;
    chk(take_o == 1'b0 && ack_o == '0, "R7 pulse", {26'd0, ack_o}, 0);
  endtask

  initial begin
    repeat (CLK_P * 20000) @(posedge clk);
    if (!done) begin
      bad++;
      applied++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    int k;
    logic [47:0] v;
    logic [5:0]  p;
    #(CLK_P * 2 + 1);
    chk(take_o == 0 && ack_o == 0, "R1 reset ctl", {26'd0, ack_o}, 0);
    chk(vec_o == 0 && entry_o == 0, "R1 reset data", entry_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: requests held while strobe low
    @(negedge clk);
    pend_i = 6'h3F; irq_en_i = 1'b1; vecs_i = 48'h0102_0304_0506; boundary_i = 1'b0;
    repeat (3) begin
      @(posedge clk); #1;
      chk(take_o == 0 && ack_o == 0, "R2 no strobe", {26'd0, ack_o}, 0);
    end

    // R3 R4 R5 R6 R9 R10: full sweep
    for (int en = 0; en < 2; en++)
      for (int pat = 0; pat < 64; pat++) begin
        for (int i = 0; i < 6; i++) v[8*i +: 8] = 8'((pat * 7 + i * 29 + en * 101 + 3) & 255);
        decide(6'(pat), 1'(en), v, 32'hFFFF_FC00 + 32'(pat * 16), k);
      end

    // R5: NMI beats maskable with enable clear and set
    decide(6'b000110, 1'b0, 48'h00_00_00_AA_BB_00, 32'h1000, k);
    chk(k == 1, "R5 model", 32'(k), 1);
    decide(6'b000100, 1'b0, 48'h00_00_00_AA_BB_00, 32'h1000, k);

    // R8: drain all sources one by one, clearing only the acknowledged one
    p = 6'h3F;
    for (int step = 0; step < 6; step++) begin
      decide(p, 1'b1, 48'h66_55_44_33_22_11, 32'h0000_8000, k);
      chk(k == step, "R8 drain order", 32'(k), 32'(step));
      if (k >= 0) p[k] = 1'b0;
    end
    decide(p, 1'b1, 48'h66_55_44_33_22_11, 32'h0000_8000, k);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule